// File: doc/BRIEF.md
# Random Byte Generator Peripheral

This peripheral produces random bytes on request. Software, or hardware task lines from other blocks, start and stop generation. Once started, the block waits for a generation period and then latches a fresh byte into a readable data register. It raises a ready flag and gives a one-cycle event pulse on an output. An interrupt line follows the ready flag when it is enabled.

The period depends on a mode bit. The faster, unfiltered setting defaults to 167 µs. The slower, filtered setting defaults to 660 µs. Periods are counted in system clocks through a clocks-per-microsecond parameter. A stop-after-one-byte option halts generation after the next byte. Without it, the timer reloads and generation continues. A free-running 16-bit LFSR stands in for the entropy source.

Software uses a 32-bit register bus with single-cycle writes and a combinational read port. All register offsets are byte offsets. Every control field sits in bit 0. The offsets are: 0x00 start task, 0x04 stop task, 0x08 ready flag, 0x0C stop-after-byte, 0x10 interrupt enable, 0x14 enable-set alias, 0x18 enable-clear alias, 0x1C filtered-mode select, 0x20 data.

Top module: `rng_gen_top`

## Requirements
- R1: After reset, every mapped register reads 0, `irq` is 0 and `evtPulse` is 0.
- R2: A write of exactly 32'h1 to offset 0x00 starts generation. The first byte is delivered P clock cycles after the write edge. A write of any other value to 0x00 has no effect.
- R3: P is FAST_US*CLK_PER_US when bit 0 of offset 0x1C is 0, and SLOW_US*CLK_PER_US when it is 1. The mode is sampled at each start and at each reload.
- R4: A delivered byte is bits [7:0] of a Galois LFSR. The LFSR shifts right with mask 16'hB400 on every clock from reset and is seeded with SEED. The byte is the LFSR value held just before the delivery edge, and offset 0x20 returns it zero-extended.
- R5: Each delivered byte gives exactly one one-cycle pulse on `evtPulse`, in the cycle after the delivery edge.
- R6: With bit 0 of 0x0C clear, generation reloads after each byte and delivers another byte every P cycles.
- R7: With bit 0 of 0x0C set, generation halts after the next byte is delivered.
- R8: A write of exactly 32'h1 to offset 0x04 halts generation and cancels the pending byte. A stop request in the same cycle as a start request wins.
- R9: A high on `hwStart` for one cycle acts as a start-task write. A high on `hwStop` for one cycle acts as a stop-task write.
- R10: Delivering a byte sets the ready flag, and offset 0x08 reads it in bit 0. Writing 0 to 0x08 clears the flag. Writing a nonzero value leaves it unchanged.
- R11: `irq` is high exactly when the interrupt enable and the ready flag are both 1.
- R12: A write to 0x10 loads the enable from data bit 0. A write to 0x14 sets the enable only when data bit 0 is 1. A write to 0x18 clears it only when data bit 0 is 1. Reads at all three offsets return the enable in bit 0.
- R13: Offsets 0x0C and 0x1C read back bit 0 as written. Reads of unmapped offsets return 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busSel | input | 1 | Bus access in this cycle |
| busWrite | input | 1 | 1 for a write, 0 for a read |
| busAddr | input | 6 | Byte offset of the register |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data (combinational, 0 when not reading) |
| hwStart | input | 1 | Hardware start task |
| hwStop | input | 1 | Hardware stop task |
| evtPulse | output | 1 | One-cycle byte-ready event |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with CLK_PER_US=2, FAST_US=3 and SLOW_US=5. This gives periods of 6 and 10 cycles, so exact cycle counts for the first byte, back-to-back bytes, and a mode change taking effect at a reload can all be measured in a short run. Windows of 25 cycles then show that stop, the stop-after-byte option and invalid task values really suppress delivery. With the default seed, each captured byte is compared against a bench model of the LFSR.

// File: rtl/rng_pkg.sv
package rng_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] OFS_START  = 6'h00;
  localparam logic [ADDR_W-1:0] OFS_STOP   = 6'h04;
  localparam logic [ADDR_W-1:0] OFS_READY  = 6'h08;
  localparam logic [ADDR_W-1:0] OFS_SHORT  = 6'h0C;
  localparam logic [ADDR_W-1:0] OFS_IEN    = 6'h10;
  localparam logic [ADDR_W-1:0] OFS_IENSET = 6'h14;
  localparam logic [ADDR_W-1:0] OFS_IENCLR = 6'h18;
  localparam logic [ADDR_W-1:0] OFS_MODE   = 6'h1C;
  localparam logic [ADDR_W-1:0] OFS_DATA   = 6'h20;

  localparam logic [31:0] TASK_FIRE = 32'h1;

  // strobes from control to datapath
  typedef struct packed {
    logic load;   // reload the period counter
    logic run;    // generation active
    logic slow;   // filtered mode selects the long period
  } tmrCtl_t;
endpackage

// File: rtl/rng_datapath.sv
module rng_datapath
  import rng_pkg::*;
#(
  parameter int CLK_PER_US = 16,
  parameter int FAST_US    = 167,
  parameter int SLOW_US    = 660,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic          clk,
  input  logic          rstN,
  input  tmrCtl_t       ctl,
  output logic          expire,
  output logic [7:0]    value
);
  localparam int FAST_CYC = FAST_US * CLK_PER_US;
  localparam int SLOW_CYC = SLOW_US * CLK_PER_US;
  localparam int MAX_CYC  = (FAST_CYC > SLOW_CYC) ? FAST_CYC : SLOW_CYC;
  localparam int CNT_W    = (MAX_CYC > 2) ? $clog2(MAX_CYC) : 1;
  localparam logic [CNT_W-1:0] FAST_LD = CNT_W'(FAST_CYC - 1);
  localparam logic [CNT_W-1:0] SLOW_LD = CNT_W'(SLOW_CYC - 1);
  localparam logic [15:0] LFSR_MASK = 16'hB400;

  logic [15:0]      lfsr;
  logic [CNT_W-1:0] count;

  // free-running Galois LFSR, maximal length, never zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) lfsr <= (SEED == 16'h0) ? 16'h1 : SEED;
    else       lfsr <= (lfsr >> 1) ^ (lfsr[0] ? LFSR_MASK : 16'h0);
  end

  // period counter: loaded with P-1, byte due when it reaches zero
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                         count <= '0;
    else if (ctl.load)                 count <= ctl.slow ? SLOW_LD : FAST_LD;
    else if (ctl.run && count != '0)   count <= count - 1'b1;
  end

  assign expire = ctl.run && (count == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       value <= '0;
    else if (expire) value <= lfsr[7:0];
  end

  a_r4_lfsr_nonzero: assert property (@(posedge clk) disable iff (!rstN)
    lfsr != 16'h0);
  a_r3_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= ((FAST_LD > SLOW_LD) ? FAST_LD : SLOW_LD));
  a_r4_value_hold: assert property (@(posedge clk) disable iff (!rstN)
    !expire |=> $stable(value));
endmodule

// File: rtl/rng_ctrl.sv
module rng_ctrl
  import rng_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              hwStart,
  input  logic              hwStop,
  input  logic              expire,
  input  logic [7:0]        value,
  output tmrCtl_t           ctl,
  output logic              evtPulse,
  output logic              irq
);
  logic wr;
  logic startReq, stopReq;
  logic active, evtFlag, shortEn, intEn, filtEn;

  assign wr       = busSel && busWrite;
  assign startReq = hwStart || (wr && busAddr == OFS_START && busWdata == TASK_FIRE);
  assign stopReq  = hwStop  || (wr && busAddr == OFS_STOP  && busWdata == TASK_FIRE);

  // stop beats start, start beats the stop-after-byte option
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                    active <= 1'b0;
    else if (stopReq)             active <= 1'b0;
    else if (startReq)            active <= 1'b1;
    else if (expire && shortEn)   active <= 1'b0;
  end

  always_comb begin
    ctl.run  = active;
    ctl.slow = filtEn;
    ctl.load = !stopReq && (startReq || (expire && !shortEn));
  end

  // a produced byte beats a clear in the same cycle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                          evtFlag <= 1'b0;
    else if (expire)                                    evtFlag <= 1'b1;
    else if (wr && busAddr == OFS_READY && busWdata == '0) evtFlag <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) evtPulse <= 1'b0;
    else       evtPulse <= expire;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shortEn <= 1'b0;
      intEn   <= 1'b0;
      filtEn  <= 1'b0;
    end else if (wr) begin
      unique case (busAddr)
        OFS_SHORT:  shortEn <= busWdata[0];
        OFS_IEN:    intEn   <= busWdata[0];
        OFS_IENSET: if (busWdata[0]) intEn <= 1'b1;
        OFS_IENCLR: if (busWdata[0]) intEn <= 1'b0;
        OFS_MODE:   filtEn  <= busWdata[0];
        default: ;
      endcase
    end
  end

  assign irq = intEn && evtFlag;

  always_comb begin
    busRdata = '0;
    if (busSel && !busWrite) begin
      unique case (busAddr)
        OFS_READY:                      busRdata = {31'h0, evtFlag};
        OFS_SHORT:                      busRdata = {31'h0, shortEn};
        OFS_IEN, OFS_IENSET, OFS_IENCLR: busRdata = {31'h0, intEn};
        OFS_MODE:                       busRdata = {31'h0, filtEn};
        OFS_DATA:                       busRdata = {24'h0, value};
        default:                        busRdata = '0;
      endcase
    end
  end

  a_r8_stop_wins: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> !active);
  a_r7_short_halt: assert property (@(posedge clk) disable iff (!rstN)
    (expire && shortEn && !startReq) |=> !active);
  a_r6_rearm: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !shortEn && !stopReq) |=> active);
  a_r10_flag_set: assert property (@(posedge clk) disable iff (!rstN)
    expire |=> evtFlag);
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    evtPulse |=> !evtPulse);
  a_r11_irq_needs_flag: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irq) |-> evtFlag);
endmodule

// File: rtl/rng_gen_top.sv
module rng_gen_top
  import rng_pkg::*;
#(
  parameter int CLK_PER_US = 16,
  parameter int FAST_US    = 167,
  parameter int SLOW_US    = 660,
  parameter logic [15:0] SEED = 16'hACE1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWrite,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWdata,
  output logic [31:0]       busRdata,
  input  logic              hwStart,
  input  logic              hwStop,
  output logic              evtPulse,
  output logic              irq
);
  tmrCtl_t    ctl;
  logic       expire;
  logic [7:0] value;

  rng_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .hwStart(hwStart), .hwStop(hwStop), .expire(expire), .value(value),
    .ctl(ctl), .evtPulse(evtPulse), .irq(irq)
  );

  rng_datapath #(
    .CLK_PER_US(CLK_PER_US), .FAST_US(FAST_US), .SLOW_US(SLOW_US), .SEED(SEED)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .expire(expire), .value(value)
  );
endmodule

// File: tb/sim_rng_gen_top.sv
module sim_rng_gen_top;
  localparam int CPU = 2, FUS = 3, SUS = 5;
  localparam int PF = CPU * FUS, PS = CPU * SUS;
  localparam logic [15:0] SEED = 16'hACE1;

  logic clk = 0, rstN = 0;
  logic busSel = 0, busWrite = 0, hwStart = 0, hwStop = 0;
  logic [5:0] busAddr = 0;
  logic [31:0] busWdata = 0, busRdata;
  logic evtPulse, irq;
  int nChk = 0, nFail = 0;
  bit done = 0;
  logic [15:0] mdl, mdlPrev;

  always #5 clk = ~clk;

  rng_gen_top #(.CLK_PER_US(CPU), .FAST_US(FUS), .SLOW_US(SUS), .SEED(SEED)) u0 (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWrite(busWrite), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .hwStart(hwStart), .hwStop(hwStop),
    .evtPulse(evtPulse), .irq(irq));

  // reference LFSR from R4
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin mdl <= SEED; mdlPrev <= SEED; end
    else begin
      mdlPrev <= mdl;
      mdl <= (mdl >> 1) ^ (mdl[0] ? 16'hB400 : 16'h0);
    end
  end

  typedef struct packed { logic wr; logic [5:0] addr; logic [31:0] data; logic [31:0] exp; } vec_t;
  localparam int NV = 20;
  localparam vec_t TBL [NV] = '{
    '{1'b1, 6'h10, 32'h1, 32'h0}, '{1'b0, 6'h10, 32'h0, 32'h1},
    '{1'b1, 6'h18, 32'h0, 32'h0}, '{1'b0, 6'h14, 32'h0, 32'h1},
    '{1'b1, 6'h18, 32'h1, 32'h0}, '{1'b0, 6'h18, 32'h0, 32'h0},
    '{1'b1, 6'h14, 32'h2, 32'h0}, '{1'b0, 6'h10, 32'h0, 32'h0},
    '{1'b1, 6'h14, 32'h1, 32'h0}, '{1'b0, 6'h10, 32'h0, 32'h1},
    '{1'b1, 6'h10, 32'h0, 32'h0}, '{1'b0, 6'h14, 32'h0, 32'h0},
    '{1'b1, 6'h0C, 32'h3, 32'h0}, '{1'b0, 6'h0C, 32'h0, 32'h1},
    '{1'b1, 6'h1C, 32'h1, 32'h0}, '{1'b0, 6'h1C, 32'h0, 32'h1},
    '{1'b1, 6'h3C, 32'hFF, 32'h0}, '{1'b0, 6'h3C, 32'h0, 32'h0},
    '{1'b1, 6'h1C, 32'h0, 32'h0}, '{1'b0, 6'h1C, 32'h0, 32'h0}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic busWr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 1; busAddr = a; busWdata = d;
    @(negedge clk); busSel = 0; busWrite = 0;
  endtask

  task automatic busRd(input logic [5:0] a, output logic [31:0] d);
    @(negedge clk); busSel = 1; busWrite = 0; busAddr = a;
    #1 d = busRdata;
    busSel = 0;
  endtask

  task automatic hwPulse(input bit st, input bit sp);
    @(negedge clk); hwStart = st; hwStop = sp;
    @(negedge clk); hwStart = 0; hwStop = 0;
  endtask

  // counts negedges until evtPulse; lim+... means none. Keeps DATA selected.
  task automatic waitPulse(input int lim, output int n, output logic [7:0] expV);
    n = 0; expV = 0;
    busSel = 1; busWrite = 0; busAddr = 6'h20;
    do begin
      @(negedge clk); n++;
    end while (!evtPulse && n < lim);
    expV = mdlPrev[7:0];
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", nChk - nFail, nChk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nChk++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    logic [7:0]  ev;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1 reset state
    foreach (TBL[i]) begin end
    begin
      logic [5:0] regs [6] = '{6'h08, 6'h0C, 6'h10, 6'h1C, 6'h20, 6'h14};
      foreach (regs[i]) begin
        busRd(regs[i], rd);
        chk(rd == 0, "R1 register after reset", rd, 0);
      end
    end
    chk(irq == 0 && evtPulse == 0, "R1 outputs after reset", {irq, evtPulse}, 0);

    // R12 R13 register table
    for (int i = 0; i < NV; i++) begin
      if (TBL[i].wr) busWr(TBL[i].addr, TBL[i].data);
      else begin
        busRd(TBL[i].addr, rd);
        chk(rd == TBL[i].exp, $sformatf("R12/R13 table row %0d", i), rd, TBL[i].exp);
      end
    end

    // R2 R3 R4 R5 R7: fast mode, stop after one byte
    busWr(6'h0C, 1);
    busWr(6'h00, 1);
    waitPulse(40, n, ev);
    chk(n == PF, "R2 R3 fast period", n, PF);
    chk(busRdata[7:0] == ev, "R4 captured byte", busRdata, ev);
    @(negedge clk);
    chk(evtPulse == 0, "R5 pulse one cycle", evtPulse, 0);
    waitPulse(25, n, ev);
    chk(n == 25 && !evtPulse, "R7 halts after byte", n, 25);
    busRd(6'h08, rd);
    chk(rd == 1, "R10 flag set", rd, 1);

    // R10 R11 flag clear and irq
    chk(irq == 0, "R11 irq off when disabled", irq, 0);
    busWr(6'h10, 1);
    chk(irq == 1, "R11 irq on", irq, 1);
    busWr(6'h08, 5);
    busRd(6'h08, rd);
    chk(rd == 1, "R10 nonzero write keeps flag", rd, 1);
    busWr(6'h08, 0);
    busRd(6'h08, rd);
    chk(rd == 0, "R10 zero write clears flag", rd, 0);
    chk(irq == 0, "R11 irq follows flag", irq, 0);
    busWr(6'h10, 0);

    // R3 R6: slow mode, continuous
    busWr(6'h0C, 0);
    busWr(6'h1C, 1);
    busWr(6'h00, 1);
    waitPulse(40, n, ev);
    chk(n == PS, "R3 slow period", n, PS);
    chk(busRdata[7:0] == ev, "R4 slow byte", busRdata, ev);
    waitPulse(40, n, ev);
    chk(n == PS, "R6 rearm period", n, PS);
    chk(busRdata[7:0] == ev, "R4 second byte", busRdata, ev);

    // R8 stop cancels
    busWr(6'h04, 1);
    waitPulse(25, n, ev);
    chk(n == 25 && !evtPulse, "R8 stop cancels", n, 25);

    // R2 invalid task value
    busWr(6'h00, 2);
    waitPulse(25, n, ev);
    chk(n == 25 && !evtPulse, "R2 non-trigger start ignored", n, 25);

    // R9 hardware tasks
    hwPulse(1, 0);
    waitPulse(40, n, ev);
    chk(n == PS, "R9 hw start", n, PS);
    hwPulse(0, 1);
    waitPulse(25, n, ev);
    chk(n == 25 && !evtPulse, "R9 hw stop", n, 25);

    // R8 stop beats start in the same cycle
    @(negedge clk); hwStart = 1; busSel = 1; busWrite = 1; busAddr = 6'h04; busWdata = 1;
    @(negedge clk); hwStart = 0; busSel = 0; busWrite = 0;
    waitPulse(25, n, ev);
    chk(n == 25 && !evtPulse, "R8 stop wins over start", n, 25);

    // R3 mode sampled at reload
    busWr(6'h1C, 0);
    busWr(6'h00, 1);
    waitPulse(40, n, ev);
    chk(n == PF, "R3 fast before change", n, PF);
    busWr(6'h1C, 1);
    waitPulse(40, n, ev);
    chk(n == PF - 2, "R3 running period unchanged", n, PF - 2);
    waitPulse(40, n, ev);
    chk(n == PS, "R3 new mode at reload", n, PS);
    chk(busRdata[7:0] == ev, "R4 byte after mode change", busRdata, ev);
    busWr(6'h04, 1);

    summary();
    done = 1;
    $finish;
  end
endmodule